// File: doc/BRIEF.md
# Dual-Channel Serial Gain Control Port

This block is a small serial control port that holds two independent 6-bit gain codes, one for each amplifier channel, and drives both codes out in parallel at all times. A host talks to it through a serial clock, a serial data line, a mode select and two active-low channel enables. All of these pins are treated as asynchronous: they are resampled on the system clock, and the block reacts to the edges it sees there.

The block has two modes. In load mode the host shifts a complete code in, most significant bit first. Releasing a channel enable then commits the shifted code to that channel's register. In count mode every serial clock pulse moves the gain code of each enabled channel one step up or down, and the code stops at the ends of the range. One shared shift register serves both channels and both modes.

Top module: `gain_serial_port`

## Requirements
- R1: While reset is asserted, both gain outputs and the internal shift register are 0, and they stay 0 until the serial pins act.
- R2: With mode high (load mode), each rising serial-clock edge shifts the shift register one place toward its most significant bit and puts the serial data bit in bit 0, whatever the enables are. Six edges form a code, first bit sent ending as the MSB.
- R3: In load mode, a rising edge (release) of a channel enable copies the shift register into that channel's gain register. Releasing both enables loads both registers.
- R4: With mode low (count mode), each rising serial-clock edge while a channel enable is low changes that channel's gain by exactly one step: up when serial data is 1, down when it is 0.
- R5: In count mode, when both enables are low, both gains step together in the same direction on the same edge.
- R6: In count mode a gain of 63 does not increment, and a gain of 0 does not decrement.
- R7: With both enables high, serial clock pulses change neither gain in either mode. Only the shift register moves.
- R8: Count mode also shifts the serial data bit into the shift register on every serial-clock rising edge, so a later release in load mode commits bits gathered in count mode.
- R9: Pin changes reach the gain outputs within three system-clock cycles, after a synchroniser two flip-flops deep. One serial-clock pulse gives one action however long it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; acts on its rising edge |
| ser_dat | input | 1 | Serial data; in count mode it sets the direction |
| mode_load | input | 1 | 1 selects load mode, 0 selects count mode |
| sel_a_n | input | 1 | Channel A enable, active low |
| sel_b_n | input | 1 | Channel B enable, active low |
| gain_a | output | 6 | Channel A gain code |
| gain_b | output | 6 | Channel B gain code |

## Verification
The bench builds the block with its default parameters: a 6-bit gain and a two-stage synchroniser. At these values the saturation limit of 63 can be reached by a single six-bit load, and the pin-to-output delay is short enough to cover with a fixed four-cycle settle. The vector walk mixes both modes and so carries shifted bits across mode changes. The directed tests reach both clamps, load a full alternating code, and apply reset in the middle of operation.

// File: rtl/gain_serial_port.sv
module gain_serial_port #(
  parameter int GAIN_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              mode_load,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  output logic [GAIN_W-1:0] gain_a,
  output logic [GAIN_W-1:0] gain_b
);
  localparam logic [GAIN_W-1:0] GMAX = '1;
  localparam logic [4:0] PIN_IDLE = 5'b11000;

  logic [4:0] pins_raw;
  logic [SYNC_STAGES:0][4:0] pipe;
  logic [4:0] cur, prv;
  logic [GAIN_W-1:0] shreg;
  logic clk_rise, rel_a, rel_b, ld_m, dat_s, act_a, act_b;

  assign pins_raw = {sel_b_n, sel_a_n, ser_clk, ser_dat, mode_load};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) pipe[i] <= PIN_IDLE;
    end else begin
      pipe[0] <= pins_raw;
      for (int i = 1; i <= SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur      = pipe[SYNC_STAGES-1];
  assign prv      = pipe[SYNC_STAGES];
  assign ld_m     = cur[0];
  assign dat_s    = cur[1];
  assign clk_rise = cur[2] & ~prv[2];
  assign rel_a    = cur[3] & ~prv[3];
  assign rel_b    = cur[4] & ~prv[4];
  assign act_a    = ~cur[3];
  assign act_b    = ~cur[4];

  function automatic logic [GAIN_W-1:0] step(input logic [GAIN_W-1:0] g, input logic up);
    if (up) return (g == GMAX) ? g : g + 1'b1;
    else    return (g == '0)   ? g : g - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (clk_rise) shreg <= {shreg[GAIN_W-2:0], dat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_a <= '0;
      gain_b <= '0;
    end else if (ld_m) begin
      if (rel_a) gain_a <= shreg;
      if (rel_b) gain_b <= shreg;
    end else if (clk_rise) begin
      if (act_a) gain_a <= step(gain_a, dat_s);
      if (act_b) gain_b <= step(gain_b, dat_s);
    end
  end
endmodule

module gain_serial_port_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_m,
  input logic              clk_rise,
  input logic              rel_a,
  input logic              act_a,
  input logic              act_b,
  input logic [GAIN_W-1:0] shreg,
  input logic [GAIN_W-1:0] gain_a,
  input logic [GAIN_W-1:0] gain_b
);
  localparam logic [GAIN_W-1:0] GMAX = '1;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (gain_a == '0 && gain_b == '0 && shreg == '0));

  p_commit_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_m && rel_a) |=> gain_a == $past(shreg));

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_m |=> (gain_a == $past(gain_a) || {1'b0, gain_a} == {1'b0, $past(gain_a)} + 1'b1
               || {1'b0, $past(gain_a)} == {1'b0, gain_a} + 1'b1));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_m && gain_a == GMAX) |=> gain_a != '0);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_m && gain_b == '0) |=> gain_b != GMAX);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_m && !act_a && !act_b) |=> ($stable(gain_a) && $stable(gain_b)));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> shreg[GAIN_W-1:1] == $past(shreg[GAIN_W-2:0]));
endmodule

bind gain_serial_port gain_serial_port_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_m(ld_m), .clk_rise(clk_rise), .rel_a(rel_a),
  .act_a(act_a), .act_b(act_b), .shreg(shreg), .gain_a(gain_a), .gain_b(gain_b)
);

// File: tb/gain_serial_port_bench.sv
module gain_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam int NVEC = 11;
  // {mode, sel_a_n, sel_b_n, dat, exp_a[5:0], exp_b[5:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b0011, 6'd1,  6'd0},
    {4'b0001, 6'd2,  6'd1},
    {4'b0100, 6'd2,  6'd0},
    {4'b0100, 6'd2,  6'd0},
    {4'b0111, 6'd2,  6'd0},
    {4'b1111, 6'd2,  6'd0},
    {4'b1010, 6'd38, 6'd0},
    {4'b1101, 6'd38, 6'd13},
    {4'b1001, 6'd27, 6'd27},
    {4'b0010, 6'd26, 6'd27},
    {4'b0001, 6'd27, 6'd28}
  };

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, mode_load = 0, sel_a_n = 1, sel_b_n = 1;
  logic [5:0] gain_a, gain_b;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_serial_port u_gain_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .mode_load(mode_load), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .gain_a(gain_a), .gain_b(gain_b)
  );

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    ser_dat = d; settle();
    ser_clk = 1; settle();
    ser_clk = 0; settle();
  endtask

  task automatic check(input string req, input logic [5:0] ea, input logic [5:0] eb);
    total++;
    if (gain_a !== ea || gain_b !== eb) begin
      bad++;
      $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d", req, gain_a, gain_b, ea, eb);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle();
    check("R1 reset", 6'd0, 6'd0);
    rst_n = 1; settle();
    check("R1 after reset", 6'd0, 6'd0);
    // vector walk covers R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      mode_load = VEC[i][15]; sel_a_n = VEC[i][14]; sel_b_n = VEC[i][13];
      settle();
      pulse(VEC[i][12]);
      sel_a_n = 1; sel_b_n = 1; settle();
      check($sformatf("R2-vector %0d (R3 R4 R5 R7 R8)", i), VEC[i][11:6], VEC[i][5:0]);
    end
    // R2 R3: full code 63 into channel A
    mode_load = 1; sel_a_n = 0; settle();
    for (int k = 0; k < 6; k++) pulse(1'b1);
    sel_a_n = 1; settle();
    check("R3 load 63 into A", 6'd63, 6'd28);
    // R6: clamp at top
    mode_load = 0; sel_a_n = 0; settle();
    pulse(1'b1);
    check("R6 hold at 63", 6'd63, 6'd28);
    // R9: a single long pulse gives one step
    ser_dat = 0; settle(); ser_clk = 1; repeat (40) @(negedge clk); ser_clk = 0; settle();
    check("R9 one step per pulse", 6'd62, 6'd28);
    sel_a_n = 1; settle();
    // R2: MSB-first code 101010 into B
    mode_load = 1; sel_b_n = 0; settle();
    for (int k = 5; k >= 0; k--) pulse(k[0] ? 1'b1 : 1'b0);
    check("R3 no commit before release", 6'd62, 6'd28);
    sel_b_n = 1; settle();
    check("R2 MSB-first load 42 into B", 6'd62, 6'd42);
    // R1: reset mid operation
    rst_n = 0; settle();
    check("R1 mid reset", 6'd0, 6'd0);
    rst_n = 1; settle();
    // R6 R5: clamp at bottom for both
    mode_load = 0; sel_a_n = 0; sel_b_n = 0; settle();
    pulse(1'b0);
    check("R6 hold at 0", 6'd0, 6'd0);
    pulse(1'b1);
    check("R5 both step up", 6'd1, 6'd1);
    sel_a_n = 1; sel_b_n = 1; settle();
    // R1: shift register cleared by reset, 01 shifted in since
    mode_load = 1; sel_a_n = 0; settle(); sel_a_n = 1; settle();
    check("R1 R8 shift reg after reset", 6'd1, 6'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule